// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block receives a stereo serial audio stream in slave mode. The external source drives a bit clock, a word-select line and a data line. The block turns that stream into pairs of parallel samples. The three serial lines are asynchronous to the block's own clock. They are resynchronised and oversampled, and every rising edge of the bit clock becomes a one-cycle sampling tick. The word-select level names the channel: low carries the left word and high carries the right word. Each change of level ends one half-frame and starts the next.

Four framings come from a 2-bit code. A separate control input selects a fifth, MSB-justified framing. Every framing yields a 20-bit two's-complement word that is left-aligned, with zero padding below shorter words. The left and right words of one frame leave together on a valid/ready output stream.

The stream follows these back-pressure rules. A pair that is offered stays offered, unchanged, until the consumer raises ready. A pair is accepted on any clock edge where valid and ready are both high. If a further frame completes while the pair is still waiting, that frame is discarded and the waiting pair is not disturbed. The block never stalls the serial source, because the serial source has no handshake.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, out_valid_o is low and stays low until a complete frame has been received.
- R2: With msb_just_i low, fmt_code_i selects the framing: 00 = I2S, 01 = LSB-justified 16-bit, 10 = LSB-justified 18-bit, 11 = LSB-justified 20-bit. With msb_just_i high, MSB-justified framing is used whatever the code.
- R3: Data and word select are sampled on rising bit-clock edges. A half-frame with word select low is the left channel, and one with word select high is the right channel.
- R4: In I2S framing, the first bit after a word-select change is ignored. The next 20 bits form the word, MSB first. Any later bits in the half are ignored.
- R5: In MSB-justified framing, the bit sampled at the word-select change is the MSB. The first 20 bits of the half form the word, and later bits are ignored.
- R6: In LSB-justified framing with length N (16, 18 or 20), the last N bits before the word-select change form the word. That word is placed in the top N output bits, and the low 20-N bits are zero. Earlier bits in the half are ignored.
- R7: Each left half followed by a right half produces exactly one output pair. The pair is offered when the right half ends, with left_o and right_o presented together.
- R8: Half-frames that are already under way when the first word-select change after reset arrives, plus a right half that has no preceding left half, produce no output.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o, left_o and right_o hold steady. Frames that complete during the stall are dropped.
- R10: The framing is taken from the format inputs at the word-select change that ends each half. The format may therefore change between halves without corrupting the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Serial bit clock from the source |
| ws_i | input | 1 | Word select, low = left, high = right |
| sd_i | input | 1 | Serial data |
| fmt_code_i | input | 2 | Framing code (see R2) |
| msb_just_i | input | 1 | Forces MSB-justified framing |
| out_valid_o | output | 1 | Sample pair offered |
| out_ready_i | input | 1 | Consumer accepts the pair |
| left_o | output | SAMPLE_W | Left sample, two's complement, left-aligned |
| right_o | output | SAMPLE_W | Right sample, two's complement, left-aligned |

## Verification
The bench builds the block with its default parameters: 20-bit samples and a two-stage input synchroniser. The 20-bit width makes all three LSB-justified lengths meaningful, together with a full 20-bit I2S word that sits in a 32-slot half. Filler bits alternate in value, so bits taken from the wrong slot show up as miscompares. The two-stage synchroniser, together with an eight-cycle bit period, keeps word select and data settled at every sampling tick. This also lets the format change between halves, which exercises the late choice of framing. A stalled consumer across two completed frames exercises the hold-and-drop rule.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S,
    FMT_LJ16,
    FMT_LJ18,
    FMT_LJ20,
    FMT_MSBJ
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic msb_just, input logic [1:0] code);
    fmt_e f;
    if (msb_just) f = FMT_MSBJ;
    else begin
      case (code)
        2'b00:   f = FMT_I2S;
        2'b01:   f = FMT_LJ16;
        2'b10:   f = FMT_LJ18;
        default: f = FMT_LJ20;
      endcase
    end
    return f;
  endfunction

  function automatic int unsigned lj_len(input fmt_e f);
    case (f)
      FMT_LJ16: return 16;
      FMT_LJ18: return 18;
      default:  return 20;
    endcase
  endfunction

endpackage

// File: rtl/sai_rx_edge.sv
module sai_rx_edge #(
  parameter int SYNC_STAGES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic ws,
  input  logic sd,
  output logic tick,
  output logic ws_bit,
  output logic sd_bit
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            bck_last;

  assign raw = {bck, ws, sd};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bck_last <= 1'b1;
    else        bck_last <= synced[2];
  end

  assign tick   = synced[2] & ~bck_last;
  assign ws_bit = synced[1];
  assign sd_bit = synced[0];

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
  import sai_rx_pkg::*;
#(
  parameter int SW = 20   // sample width, at least 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ws_bit,
  input  logic          sd_bit,
  input  fmt_e          fmt,
  output logic          push,
  output logic [SW-1:0] left_w,
  output logic [SW-1:0] right_w
);
  localparam int HEAD_W = SW + 1;
  localparam int CNT_W  = $clog2(HEAD_W + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(HEAD_W);
  localparam logic [HEAD_W-1:0] TOP_BIT = {1'b1, {SW{1'b0}}};

  logic              armed, synced, ws_prev, left_ok;
  logic [CNT_W-1:0]  cnt;
  logic [HEAD_W-1:0] head;     // first slots of the half, left-aligned
  logic [SW-1:0]     roll;     // most recent bits, for right-aligned framing
  logic [SW-1:0]     left_hold, right_hold;
  logic [SW-1:0]     word;
  logic [HEAD_W-1:0] slot_mask;

  assign slot_mask = TOP_BIT >> cnt;

  // framing is chosen only when a half closes
  always_comb begin
    case (fmt)
      FMT_I2S:  word = head[SW-1:0];
      FMT_MSBJ: word = head[SW:1];
      default:  word = roll << (SW - lj_len(fmt));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      synced     <= 1'b0;
      ws_prev    <= 1'b0;
      left_ok    <= 1'b0;
      cnt        <= CNT_MAX;
      head       <= '0;
      roll       <= '0;
      left_hold  <= '0;
      right_hold <= '0;
      push       <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        roll    <= {roll[SW-2:0], sd_bit};
        ws_prev <= ws_bit;
        armed   <= 1'b1;
        if (armed && (ws_bit != ws_prev)) begin
          synced <= 1'b1;
          cnt    <= CNT_W'(1);
          head   <= {sd_bit, {SW{1'b0}}};
          if (synced) begin
            if (!ws_prev) begin
              left_hold <= word;
              left_ok   <= 1'b1;
            end else begin
              left_ok <= 1'b0;
              if (left_ok) begin
                right_hold <= word;
                push       <= 1'b1;
              end
            end
          end
        end else if (armed) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          head <= sd_bit ? (head | slot_mask) : (head & ~slot_mask);
        end
      end
    end
  end

  assign left_w  = left_hold;
  assign right_w = right_hold;

  // R7
  push_at_left_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(tick) && !$past(ws_bit)));

  // R8
  push_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(synced));

endmodule

// File: rtl/sai_rx_outreg.sv
module sai_rx_outreg #(
  parameter int SW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] left_in,
  input  logic [SW-1:0] right_in,
  input  logic          ready,
  output logic          valid,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out
);
  logic load;

  // a slot is free when empty or being drained this cycle
  assign load = push && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
    end else begin
      if (load) begin
        valid     <= 1'b1;
        left_out  <= left_in;
        right_out <= right_in;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(left_out) && $stable(right_out)));

  // R7
  valid_from_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(push));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_code_i,
  input  logic                msb_just_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic                tick, ws_bit, sd_bit, push;
  logic [SAMPLE_W-1:0] left_w, right_w;
  fmt_e                fmt;

  assign fmt = decode_fmt(msb_just_i, fmt_code_i);

  sai_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .bck(bck_i), .ws(ws_i), .sd(sd_i),
    .tick(tick), .ws_bit(ws_bit), .sd_bit(sd_bit)
  );

  sai_rx_deser #(.SW(SAMPLE_W)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .ws_bit(ws_bit), .sd_bit(sd_bit), .fmt(fmt),
    .push(push), .left_w(left_w), .right_w(right_w)
  );

  sai_rx_outreg #(.SW(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .push(push), .left_in(left_w), .right_in(right_w),
    .ready(out_ready_i), .valid(out_valid_o),
    .left_out(left_o), .right_out(right_o)
  );

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bck, ws, sd, msb_just, out_ready, out_valid;
  logic [1:0]  fmt_code;
  logic [19:0] left, right;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd),
    .fmt_code_i(fmt_code), .msb_just_i(msb_just),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .left_o(left), .right_o(right)
  );

  typedef struct packed {
    logic        msb;
    logic [1:0]  code;
    logic [19:0] l;
    logic [19:0] r;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 20'h81234, 20'h7FEDC},
    '{1'b0, 2'b00, 20'hFFFFF, 20'h00001},
    '{1'b0, 2'b01, 20'hA5A5F, 20'h5A5A0},
    '{1'b0, 2'b01, 20'h80001, 20'h7FFFF},
    '{1'b0, 2'b10, 20'hC3C3C, 20'h3C3C3},
    '{1'b0, 2'b11, 20'h12345, 20'hEDCBA},
    '{1'b1, 2'b00, 20'h9ABCD, 20'h65432},
    '{1'b1, 2'b11, 20'h80000, 20'h7FFFF},
    '{1'b0, 2'b10, 20'h00003, 20'hFFFFC},
    '{1'b0, 2'b00, 20'h00000, 20'h80000}
  };
  localparam vec_t BP_A = '{1'b0, 2'b11, 20'h4C4C4, 20'hB3B3B};
  localparam vec_t BP_B = '{1'b0, 2'b11, 20'h11111, 20'h22222};

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [19:0] cap_l [16];
  logic [19:0] cap_r [16];

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (cap_n < 16) begin
        cap_l[cap_n] = left;
        cap_r[cap_n] = right;
      end
      cap_n++;
    end
  end

  function automatic int word_len(input logic m, input logic [1:0] c);
    if (m) return 20;
    case (c)
      2'b01:   return 16;
      2'b10:   return 18;
      default: return 20;
    endcase
  endfunction

  function automatic logic [19:0] expect_w(input logic m, input logic [1:0] c, input logic [19:0] x);
    logic [19:0] mask;
    mask = 20'hFFFFF << (20 - word_len(m, c));
    return x & mask;
  endfunction

  function automatic logic slot_bit(input logic m, input logic [1:0] c, input logic [19:0] x, input int k);
    logic junk;
    int n;
    junk = (k % 2 == 0);
    n = word_len(m, c);
    if (m)              return (k < 20) ? x[19-k] : junk;
    else if (c == 2'b00) return (k >= 1 && k <= 20) ? x[20-k] : junk;
    else                return (k >= 32 - n) ? x[19-(k-(32-n))] : junk;
  endfunction

  function automatic string tag(input logic m, input logic [1:0] c);
    if (m) return "R5";
    if (c == 2'b00) return "R4";
    return "R6";
  endfunction

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    bck = 1'b0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic w, input vec_t v, input logic [19:0] x, input int from);
    for (int k = from; k < 32; k++) send_bit(w, slot_bit(v.msb, v.code, x, k));
  endtask

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; bck = 1'b0; ws = 1'b0; sd = 1'b0;
    fmt_code = 2'b00; msb_just = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset valid", {19'd0, out_valid}, 20'd0);

    // R8: partial left half, then a right half with no left before it
    for (int k = 0; k < 10; k++) send_bit(1'b0, k[0]);
    for (int k = 0; k < 32; k++) send_bit(1'b1, ~k[0]);

    // table walk; the format switches after slot 0 of each left half (R10)
    for (int i = 0; i < NV; i++) begin
      send_bit(1'b0, slot_bit(VEC[i].msb, VEC[i].code, VEC[i].l, 0));
      fmt_code = VEC[i].code;
      msb_just = VEC[i].msb;
      send_half(1'b0, VEC[i], VEC[i].l, 1);
      send_half(1'b1, VEC[i], VEC[i].r, 0);
      if (i == 0) check("R8 no output from startup halves", 20'(cap_n), 20'd0);
    end
    send_bit(1'b0, 1'b0);
    repeat (10) @(negedge clk);
    // R7
    check("R7 one pair per frame", 20'(cap_n), 20'(NV + 0));
    for (int i = 0; i < NV; i++) begin
      check($sformatf("R2 R3 R10 %s left vec %0d", tag(VEC[i].msb, VEC[i].code), i),
            cap_l[i], expect_w(VEC[i].msb, VEC[i].code, VEC[i].l));
      check($sformatf("R2 R3 R10 %s right vec %0d", tag(VEC[i].msb, VEC[i].code), i),
            cap_r[i], expect_w(VEC[i].msb, VEC[i].code, VEC[i].r));
    end

    // R9: stall across two frames
    out_ready = 1'b0;
    fmt_code  = BP_A.code;
    msb_just  = BP_A.msb;
    send_half(1'b0, BP_A, BP_A.l, 1);
    send_half(1'b1, BP_A, BP_A.r, 0);
    send_bit(1'b0, slot_bit(BP_B.msb, BP_B.code, BP_B.l, 0));
    repeat (4) @(negedge clk);
    check("R9 valid while stalled", {19'd0, out_valid}, 20'd1);
    check("R9 left offered", left, BP_A.l);
    check("R9 right offered", right, BP_A.r);
    send_half(1'b0, BP_B, BP_B.l, 1);
    send_half(1'b1, BP_B, BP_B.r, 0);
    send_bit(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 left held across second frame", left, BP_A.l);
    check("R9 right held across second frame", right, BP_A.r);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 single accept", 20'(cap_n), 20'(NV + 1));
    check("R9 accepted left", cap_l[NV], BP_A.l);
    check("R9 stalled frame dropped", {19'd0, out_valid}, 20'd0);

    summary();
  end

endmodule